// File: doc/BRIEF.md
# PIO Cycle Timer

This block times one host-side programmed-I/O transfer on a parallel ATA-style disk bus. A one-clock start pulse launches the transfer. Along with it come a direction bit and four run-time durations counted in clock ticks: address setup before the strobe, strobe active width, write data hold after the strobe, and end-of-cycle recovery. The block drives active-high read and write strobes and an output enable for the data bus. During reads it issues a one-clock capture pulse for external data latching. It signals completion with a one-clock done pulse.

When ready handshaking is enabled, a device that holds its ready line low can stretch the strobe past its programmed width. The ready line passes through a two-flop synchroniser first. At 100 MHz, the slowest legal timing is 6/28/2/23 ticks, which gives a 600 ns cycle. The recovery count covers what remains of the total cycle after setup and strobe. Address decoding, register selection and data storage belong to the surrounding logic.

Top module: `pio_cycle_timer`

## Requirements
- R1: After the asynchronous reset (`arst_n` low) or the synchronous reset (`rst` high at a clock edge), all five outputs are low and the block is idle. A cycle in progress is abandoned.
- R2: Count cycles from the rising edge that accepts `start`, with cycle 0 beginning at that edge. Let d(x) = max(x,1). No strobe is high in cycles 0 to d(setup)-1. The selected strobe is high from cycle d(setup) for d(active) cycles, unless R4 extends it.
- R3: `dir_wr`=1 selects `wr_strb` and `dir_wr`=0 selects `rd_strb`. The strobe that was not selected stays low for the whole cycle, and the two are never high together.
- R4: With `rdy_wait_en`=1, the strobe ends on the later of two cycles: the last cycle of its programmed width, or the first cycle in which the two-flop-synchronised `dev_rdy` is high. A `dev_rdy` rise in the middle of cycle m is therefore seen in cycle m+2. With `rdy_wait_en`=0, `dev_rdy` has no effect.
- R5: In a read, `cap_strb` is high for exactly one clock: the first cycle after `rd_strb` falls. It never pulses in a write.
- R6: In a write, `bus_oe` is high from cycle 0 to the end of the d(hold) cycles that follow the write strobe. It is never high in a read.
- R7: After the hold phase, the recovery phase lasts d(recov) cycles. Then `cyc_done` is high for exactly one cycle, and the next cycle is idle.
- R8: A `start` that arrives while a cycle is in progress, including its done cycle, is ignored. It neither restarts nor extends the cycle, and it launches no later cycle.
- R9: The direction, the ready enable and the four durations are sampled in the cycle that accepts `start`. Later changes to them have no effect on that cycle.
- R10: A duration of zero behaves exactly like a duration of one tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| arst_n | input | 1 | Asynchronous reset, active low |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | One-clock request to begin a cycle |
| dir_wr | input | 1 | 1 = write, 0 = read |
| rdy_wait_en | input | 1 | Allow the device ready line to stretch the strobe |
| setup_ticks | input | TW | Address setup duration |
| active_ticks | input | TW | Strobe active duration |
| hold_ticks | input | TW | Write data hold duration |
| recov_ticks | input | TW | End-of-cycle recovery duration |
| dev_rdy | input | 1 | Device ready line, asynchronous |
| rd_strb | output | 1 | Read strobe, active high |
| wr_strb | output | 1 | Write strobe, active high |
| bus_oe | output | 1 | Data bus output enable |
| cap_strb | output | 1 | Read data capture pulse |
| cyc_done | output | 1 | Cycle complete pulse |

## Verification
The assertions assume that the two resets are the only things that abandon a cycle. They also assume that `dev_rdy` only affects the strobe through its synchronised copy, so any properties involving ready refer to the synchronised value. The bench meets both assumptions. It changes `dev_rdy` only at falling clock edges, and it holds ready steady for at least three cycles before each start, so the synchroniser has settled. It changes the timing inputs, direction and enable straight after each start so that R9 is exercised. It also sends extra start pulses only at known cycle indices, which lets the expected phase boundaries be computed exactly.

// File: rtl/pio_timer_pkg.sv
package pio_timer_pkg;

  typedef enum logic [2:0] {
    PH_IDLE   = 3'd0,
    PH_SETUP  = 3'd1,
    PH_STROBE = 3'd2,
    PH_HOLD   = 3'd3,
    PH_RECOV  = 3'd4,
    PH_DONE   = 3'd5
  } pio_phase_e;

  localparam int RDY_SYNC_STAGES = 2;

endpackage

// File: rtl/pio_rdy_sync.sv
module pio_rdy_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  input  logic rst,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n)   chain_q <= '0;
    else if (rst)  chain_q <= '0;
    else           chain_q <= {chain_q[STAGES-2:0], din};
  end

  assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/pio_phase_cnt.sv
module pio_phase_cnt #(
  parameter int TW = 8
) (
  input  logic          clk,
  input  logic          arst_n,
  input  logic          rst,
  input  logic          load,
  input  logic [TW-1:0] load_val,
  output logic          expired
);
  logic [TW-1:0] cnt_q;

  // Preload d(x)-1 so the phase lasts max(x,1) cycles; holds at zero.
  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n)                cnt_q <= '0;
    else if (rst)               cnt_q <= '0;
    else if (load)              cnt_q <= (load_val == '0) ? '0 : load_val - 1'b1;
    else if (cnt_q != '0)       cnt_q <= cnt_q - 1'b1;
  end

  assign expired = (cnt_q == '0);
endmodule

// File: rtl/pio_seq_fsm.sv
module pio_seq_fsm
  import pio_timer_pkg::*;
#(
  parameter int TW = 8
) (
  input  logic          clk,
  input  logic          arst_n,
  input  logic          rst,
  input  logic          start,
  input  logic          dir_wr,
  input  logic          rdy_wait_en,
  input  logic [TW-1:0] setup_ticks,
  input  logic [TW-1:0] active_ticks,
  input  logic [TW-1:0] hold_ticks,
  input  logic [TW-1:0] recov_ticks,
  input  logic          rdy_s,
  input  logic          expired,
  output logic          cnt_load,
  output logic [TW-1:0] cnt_val,
  output logic          rd_strb,
  output logic          wr_strb,
  output logic          bus_oe,
  output logic          cap_strb,
  output logic          cyc_done
);
  pio_phase_e    state_q, state_d;
  logic          wr_q, wr_d, wait_q;
  logic [TW-1:0] act_q, hold_q, recov_q;
  logic          accept;

  assign accept = (state_q == PH_IDLE) && start;

  always_comb begin
    state_d  = state_q;
    wr_d     = wr_q;
    cnt_load = 1'b0;
    cnt_val  = setup_ticks;
    case (state_q)
      PH_IDLE: if (start) begin
        state_d  = PH_SETUP;
        wr_d     = dir_wr;
        cnt_load = 1'b1;
        cnt_val  = setup_ticks;
      end
      PH_SETUP: if (expired) begin
        state_d  = PH_STROBE;
        cnt_load = 1'b1;
        cnt_val  = act_q;
      end
      PH_STROBE: if (expired && (!wait_q || rdy_s)) begin
        state_d  = PH_HOLD;
        cnt_load = 1'b1;
        cnt_val  = hold_q;
      end
      PH_HOLD: if (expired) begin
        state_d  = PH_RECOV;
        cnt_load = 1'b1;
        cnt_val  = recov_q;
      end
      PH_RECOV: if (expired) state_d = PH_DONE;
      PH_DONE:  state_d = PH_IDLE;
      default:  state_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      state_q <= PH_IDLE;
      wr_q    <= 1'b0;
      wait_q  <= 1'b0;
      act_q   <= '0;
      hold_q  <= '0;
      recov_q <= '0;
      rd_strb <= 1'b0;
      wr_strb <= 1'b0;
      bus_oe  <= 1'b0;
      cap_strb <= 1'b0;
      cyc_done <= 1'b0;
    end else if (rst) begin
      state_q <= PH_IDLE;
      wr_q    <= 1'b0;
      wait_q  <= 1'b0;
      act_q   <= '0;
      hold_q  <= '0;
      recov_q <= '0;
      rd_strb <= 1'b0;
      wr_strb <= 1'b0;
      bus_oe  <= 1'b0;
      cap_strb <= 1'b0;
      cyc_done <= 1'b0;
    end else begin
      state_q <= state_d;
      wr_q    <= wr_d;
      if (accept) begin
        wait_q  <= rdy_wait_en;
        act_q   <= active_ticks;
        hold_q  <= hold_ticks;
        recov_q <= recov_ticks;
      end
      rd_strb  <= (state_d == PH_STROBE) && !wr_d;
      wr_strb  <= (state_d == PH_STROBE) && wr_d;
      bus_oe   <= wr_d && (state_d inside {PH_SETUP, PH_STROBE, PH_HOLD});
      cap_strb <= !wr_q && (state_q == PH_STROBE) && (state_d == PH_HOLD);
      cyc_done <= (state_d == PH_DONE);
    end
  end

  // R3: at most one strobe at a time
  a_r3_one_strobe: assert property (@(posedge clk) disable iff (rst || !arst_n)
    $onehot0({rd_strb, wr_strb}));

  // R6: output enable covers every write strobe and no read strobe
  a_r6_oe_with_write: assert property (@(posedge clk) disable iff (rst || !arst_n)
    wr_strb |-> bus_oe);
  a_r6_no_oe_in_read: assert property (@(posedge clk) disable iff (rst || !arst_n)
    rd_strb |-> !bus_oe);

  // R5: capture pulse follows the fall of the read strobe
  a_r5_cap_after_read: assert property (@(posedge clk) disable iff (rst || !arst_n)
    cap_strb |-> ($past(rd_strb) && !rd_strb));

  // R7: completion pulse lasts one cycle
  a_r7_done_single: assert property (@(posedge clk) disable iff (rst || !arst_n)
    cyc_done |=> !cyc_done);

  // R4: strobe is held while the enabled handshake sees ready low
  a_r4_wait_holds: assert property (@(posedge clk) disable iff (rst || !arst_n)
    (state_q == PH_STROBE && wait_q && !rdy_s) |=> (state_q == PH_STROBE));

  // R8: a start during a busy phase never re-enters setup
  a_r8_busy_ignored: assert property (@(posedge clk) disable iff (rst || !arst_n)
    ((state_q inside {PH_STROBE, PH_HOLD, PH_RECOV, PH_DONE}) && start)
      |=> (state_q != PH_SETUP));
endmodule

// File: rtl/pio_cycle_timer.sv
module pio_cycle_timer
  import pio_timer_pkg::*;
#(
  parameter int TW = 8
) (
  input  logic          clk,
  input  logic          arst_n,
  input  logic          rst,
  input  logic          start,
  input  logic          dir_wr,
  input  logic          rdy_wait_en,
  input  logic [TW-1:0] setup_ticks,
  input  logic [TW-1:0] active_ticks,
  input  logic [TW-1:0] hold_ticks,
  input  logic [TW-1:0] recov_ticks,
  input  logic          dev_rdy,
  output logic          rd_strb,
  output logic          wr_strb,
  output logic          bus_oe,
  output logic          cap_strb,
  output logic          cyc_done
);
  logic          rdy_s;
  logic          expired;
  logic          cnt_load;
  logic [TW-1:0] cnt_val;

  pio_rdy_sync #(.STAGES(RDY_SYNC_STAGES)) u_sync (
    .clk(clk), .arst_n(arst_n), .rst(rst), .din(dev_rdy), .dout(rdy_s)
  );

  pio_phase_cnt #(.TW(TW)) u_cnt (
    .clk(clk), .arst_n(arst_n), .rst(rst),
    .load(cnt_load), .load_val(cnt_val), .expired(expired)
  );

  pio_seq_fsm #(.TW(TW)) u_fsm (
    .clk(clk), .arst_n(arst_n), .rst(rst),
    .start(start), .dir_wr(dir_wr), .rdy_wait_en(rdy_wait_en),
    .setup_ticks(setup_ticks), .active_ticks(active_ticks),
    .hold_ticks(hold_ticks), .recov_ticks(recov_ticks),
    .rdy_s(rdy_s), .expired(expired),
    .cnt_load(cnt_load), .cnt_val(cnt_val),
    .rd_strb(rd_strb), .wr_strb(wr_strb), .bus_oe(bus_oe),
    .cap_strb(cap_strb), .cyc_done(cyc_done)
  );
endmodule

// File: tb/pio_cycle_timer_bench.sv
module pio_cycle_timer_bench;
  localparam int TW = 8;

  logic clk = 1'b0;
  logic arst_n = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic dir_wr = 1'b0;
  logic rdy_wait_en = 1'b0;
  logic [TW-1:0] setup_ticks = '0;
  logic [TW-1:0] active_ticks = '0;
  logic [TW-1:0] hold_ticks = '0;
  logic [TW-1:0] recov_ticks = '0;
  logic dev_rdy = 1'b1;
  logic rd_strb, wr_strb, bus_oe, cap_strb, cyc_done;

  int tests = 0;
  int failed = 0;

  always #5 clk = ~clk;

  pio_cycle_timer #(.TW(TW)) u_pio_cycle_timer (
    .clk(clk), .arst_n(arst_n), .rst(rst), .start(start), .dir_wr(dir_wr),
    .rdy_wait_en(rdy_wait_en), .setup_ticks(setup_ticks),
    .active_ticks(active_ticks), .hold_ticks(hold_ticks),
    .recov_ticks(recov_ticks), .dev_rdy(dev_rdy),
    .rd_strb(rd_strb), .wr_strb(wr_strb), .bus_oe(bus_oe),
    .cap_strb(cap_strb), .cyc_done(cyc_done)
  );

  // {wr, wait_en, setup, active, hold, recov, ready_rise_cycle (0 = ready high)}
  localparam int NVEC = 9;
  localparam logic [55:0] VEC [NVEC] = '{
    {8'd1, 8'd0, 8'd6, 8'd28, 8'd2, 8'd23, 8'd0},
    {8'd0, 8'd0, 8'd6, 8'd28, 8'd2, 8'd23, 8'd0},
    {8'd0, 8'd1, 8'd3, 8'd4,  8'd1, 8'd2,  8'd15},
    {8'd1, 8'd1, 8'd2, 8'd5,  8'd3, 8'd1,  8'd12},
    {8'd0, 8'd1, 8'd2, 8'd6,  8'd1, 8'd1,  8'd0},
    {8'd0, 8'd0, 8'd2, 8'd3,  8'd1, 8'd1,  8'd9},
    {8'd1, 8'd0, 8'd0, 8'd0,  8'd0, 8'd0,  8'd0},
    {8'd0, 8'd0, 8'd0, 8'd1,  8'd0, 8'd0,  8'd0},
    {8'd1, 8'd1, 8'd1, 8'd8,  8'd2, 8'd2,  8'd2}
  };

  task automatic chk(input string req, input string what, input int act, input int exp);
    tests++;
    if (act != exp) begin
      failed++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int eff(input int v);
    return (v == 0) ? 1 : v;
  endfunction

  task automatic run_cycle(input int wr_i, input int wt, input int t1, input int t2,
                           input int t4, input int te, input int rdy_at, input int poke);
    int d1, d2, d4, de, last, s2, exp_done;
    int rf, rc, wf, wc, of, oc, cf, cc, df, dc;
    string wreq, dreq;
    rf = -1; rc = 0; wf = -1; wc = 0; of = -1; oc = 0;
    cf = -1; cc = 0; df = -1; dc = 0;
    d1 = eff(t1); d2 = eff(t2); d4 = eff(t4); de = eff(te);
    last = d1 + d2 - 1;
    if (wt != 0 && rdy_at > 0 && rdy_at + 2 > last) last = rdy_at + 2;
    s2 = last - d1 + 1;
    exp_done = d1 + s2 + d4 + de;
    wreq = (wt != 0) ? "R4" : "R2";
    dreq = (t1 == 0 || t2 == 0 || t4 == 0 || te == 0) ? "R10" : "R7";
    @(negedge clk);
    dev_rdy = (rdy_at == 0);
    repeat (3) @(negedge clk);
    dir_wr = (wr_i != 0); rdy_wait_en = (wt != 0);
    setup_ticks = t1[TW-1:0]; active_ticks = t2[TW-1:0];
    hold_ticks = t4[TW-1:0]; recov_ticks = te[TW-1:0];
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    // R9: disturb every sampled input once the cycle is under way
    dir_wr = ~dir_wr; rdy_wait_en = ~rdy_wait_en;
    setup_ticks = 8'd1; active_ticks = 8'd1; hold_ticks = 8'd1; recov_ticks = 8'd1;
    for (int i = 0; i <= exp_done + 8; i++) begin
      if (rd_strb)  begin if (rf < 0) rf = i; rc++; end
      if (wr_strb)  begin if (wf < 0) wf = i; wc++; end
      if (bus_oe)   begin if (of < 0) of = i; oc++; end
      if (cap_strb) begin if (cf < 0) cf = i; cc++; end
      if (cyc_done) begin if (df < 0) df = i; dc++; end
      if (rdy_at > 0 && i == rdy_at) dev_rdy = 1'b1;
      start = (i == poke);
      @(negedge clk);
    end
    start = 1'b0;
    dev_rdy = 1'b1;
    if (wr_i != 0) begin
      chk("R2", "write strobe first cycle", wf, d1);
      chk(wreq, "write strobe width", wc, s2);
      chk("R3", "read strobe count in write (R9 dir change)", rc, 0);
      chk("R6", "oe first cycle", of, 0);
      chk("R6", "oe length", oc, d1 + s2 + d4);
      chk("R5", "capture count in write", cc, 0);
    end else begin
      chk("R2", "read strobe first cycle", rf, d1);
      chk(wreq, "read strobe width", rc, s2);
      chk("R3", "write strobe count in read (R9 dir change)", wc, 0);
      chk("R6", "oe count in read", oc, 0);
      chk("R5", "capture cycle", cf, d1 + s2);
      chk("R5", "capture count", cc, 1);
    end
    chk(dreq, "done cycle", df, exp_done);
    chk("R7", "done count", dc, 1);
  endtask

  function automatic int outs();
    return {27'd0, rd_strb, wr_strb, bus_oe, cap_strb, cyc_done};
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    tests++;
    failed++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, failed);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    arst_n = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1", "outputs after reset", outs(), 0);

    for (int v = 0; v < NVEC; v++) begin
      run_cycle(int'(VEC[v][55:48]), int'(VEC[v][47:40]), int'(VEC[v][39:32]),
                int'(VEC[v][31:24]), int'(VEC[v][23:16]), int'(VEC[v][15:8]),
                int'(VEC[v][7:0]), -1);
    end

    // R8: start pulses during the strobe and during the done cycle
    run_cycle(0, 0, 2, 4, 1, 2, 0, 3);
    run_cycle(1, 0, 2, 4, 1, 2, 0, 9);

    // R1: asynchronous reset in the middle of a write
    @(negedge clk);
    dir_wr = 1'b1; rdy_wait_en = 1'b0;
    setup_ticks = 8'd5; active_ticks = 8'd10; hold_ticks = 8'd2; recov_ticks = 8'd2;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (2) @(negedge clk);
    chk("R6", "oe high before async reset", int'(bus_oe), 1);
    arst_n = 1'b0;
    #1;
    chk("R1", "outputs during async reset", outs(), 0);
    @(negedge clk);
    arst_n = 1'b1;
    repeat (20) @(negedge clk);
    chk("R1", "idle after async reset", outs(), 0);

    // R1: synchronous reset in the middle of a read strobe
    dir_wr = 1'b0;
    setup_ticks = 8'd2; active_ticks = 8'd10;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (4) @(negedge clk);
    chk("R2", "read strobe high before sync reset", int'(rd_strb), 1);
    rst = 1'b1;
    @(negedge clk);
    chk("R1", "outputs after sync reset", outs(), 0);
    rst = 1'b0;
    repeat (20) @(negedge clk);
    chk("R1", "idle after sync reset", outs(), 0);

    // R1: normal operation resumes
    run_cycle(1, 0, 3, 3, 2, 2, 0, -1);

    $display("  [TB] %0d tests run, %0d failed", tests, failed);
    $finish;
  end
endmodule